// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets a synchronous, single-port request interface read and write an external asynchronous static RAM of 128K words by 8 bits. A client offers a request (address, write flag, write data) while `ready_o` is high. The controller then runs one bus cycle on the memory pins and, when the cycle is over, pulses `done_o`. For a read, the byte it captured is returned on `rdata_o`.

Each memory bus phase lasts a parameterised whole number of clock cycles, chosen to fit the speed grade of the part. The phases are the read access, the write address setup, the write-enable pulse and the write hold. Writes are controlled by the write-enable line, and output-enable stays high for the whole write, so the shorter minimum write pulse applies. The data driver in the FPGA turns on only during the write pulse. At least one cycle with the bus floating always separates a read from the next write, which lets the memory release the bus first. Between requests, chip-enable stays high, so the memory sits in its power-down standby state.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, chip-enable, output-enable and write-enable (all active low) are high, the data driver is off, `ready_o` is 1 and `done_o` is 0.
- R2: While no request is in progress, chip-enable stays high and the data driver stays off.
- R3: A read holds chip-enable low, output-enable low and write-enable high for READ_CYC cycles with the request address on the memory address pins. It captures `mem_dq_i` on the last of those cycles. In the next cycle `done_o` and `ready_o` are 1 and `rdata_o` holds the captured byte.
- R4: A write runs three phases with chip-enable low and the request address on the pins. First come SETUP_CYC cycles with write-enable high and the driver off. Then come PULSE_CYC cycles with write-enable low, the driver on and the write data on `mem_dq_o`. Then come HOLD_CYC cycles with write-enable high and the driver off. `done_o` follows in the next cycle.
- R5: Output-enable is high in every cycle in which write-enable is low.
- R6: The data driver is on only while write-enable is low and output-enable is high.
- R7: The data driver is never on in the cycle that follows a cycle with output-enable low.
- R8: The memory address does not change while chip-enable stays low.
- R9: A request offered while the controller is busy is ignored. It does not change the address in use, and it does not start a transaction once the controller is idle again.
- R10: `ready_o` is 0 whenever chip-enable is low, and `done_o` is high for exactly one cycle per transaction.
- R11: `rdata_o` keeps its value until the next read completes; writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Idle, request accepted at next edge if offered |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 8 | Byte returned by the last read |
| mem_addr_o | output | 17 | Memory address pins |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_i | input | 8 | Data received from memory |
| mem_dq_oe_o | output | 1 | Tri-state enable for mem_dq_o |

## Verification
The stimulus writes and reads back the lowest and highest addresses and a mid-range address. It also overwrites a location, which tells a real memory update apart from stale or mis-addressed data. Reads follow writes and writes follow reads back to back, so every pin is checked cycle by cycle across the turnaround. A separate case offers a conflicting request in the middle of a write, to show that a busy controller ignores it. A write placed after a read confirms that the returned byte is left alone. A behavioural memory answers reads with a distinct filler byte whenever it is not selected, so a capture taken in the wrong cycle shows up.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_WSETUP,
    PH_WPULSE,
    PH_WHOLD
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drv;
  } pins_t;

  function automatic pins_t pins_of(phase_e ph);
    pins_t p;
    p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
    case (ph)
      PH_READ:   begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
      PH_WSETUP: p.ce_n = 1'b0;
      PH_WPULSE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.drv = 1'b1; end
      PH_WHOLD:  p.ce_n = 1'b0;
      default:   ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_valid_i,
  input  logic  req_we_i,
  output logic  accept_o,
  output logic  capture_o,
  output logic  ready_o,
  output logic  done_o,
  output pins_t pins_o
);

  localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B   = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] LD_SU = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LD_PW = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] LD_HD = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] LD_RD = CW'(READ_CYC - 1);

  phase_e        state_q, state_d;
  logic          load, last, fin, done_q;
  logic [CW-1:0] load_val;

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_val  = '0;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    fin       = 1'b0;
    case (state_q)
      PH_IDLE: if (req_valid_i) begin
        accept_o = 1'b1;
        load     = 1'b1;
        if (req_we_i) begin state_d = PH_WSETUP; load_val = LD_SU; end
        else          begin state_d = PH_READ;   load_val = LD_RD; end
      end
      PH_READ: if (last) begin
        capture_o = 1'b1;
        fin       = 1'b1;
        state_d   = PH_IDLE;
      end
      PH_WSETUP: if (last) begin
        state_d = PH_WPULSE; load = 1'b1; load_val = LD_PW;
      end
      PH_WPULSE: if (last) begin
        state_d = PH_WHOLD; load = 1'b1; load_val = LD_HD;
      end
      PH_WHOLD: if (last) begin
        fin     = 1'b1;
        state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  assign ready_o = (state_q == PH_IDLE);
  assign done_o  = done_q;
  assign pins_o  = pins_of(state_q);

  // write pulse length monitor
  logic [CW:0] we_low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            we_low_cnt <= '0;
    else if (!pins_o.we_n)  we_low_cnt <= we_low_cnt + 1'b1;
    else                    we_low_cnt <= '0;
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (pins_o.ce_n && !pins_o.drv)); // R2
  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pins_o.we_n) |-> (we_low_cnt == (CW+1)'(PULSE_CYC))); // R4
  AST_WRITE_OE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pins_o.we_n |-> pins_o.oe_n); // R5
  AST_DRV_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_o.drv |-> (!pins_o.we_n && pins_o.oe_n)); // R6
  AST_TURNAROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pins_o.oe_n |=> !pins_o.drv); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= req_addr_i;
      wdata_o <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= mem_dq_i;
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic [DW-1:0] mem_dq_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_dq_oe_o
);

  logic  accept, capture;
  pins_t pins;

  sram_ctrl_seq #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .READ_CYC  (READ_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .accept_o    (accept),
    .capture_o   (capture),
    .ready_o     (ready_o),
    .done_o      (done_o),
    .pins_o      (pins)
  );

  sram_ctrl_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .mem_dq_i    (mem_dq_i),
    .addr_o      (mem_addr_o),
    .wdata_o     (mem_dq_o),
    .rdata_o     (rdata_o)
  );

  assign mem_ce_no   = pins.ce_n;
  assign mem_oe_no   = pins.oe_n;
  assign mem_we_no   = pins.we_n;
  assign mem_dq_oe_o = pins.drv;

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> !ready_o); // R10
  AST_RDATA_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!mem_we_no) || $past(mem_oe_no)) |-> $stable(rdata_o)); // R11

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

  localparam int SU = 1, PW = 2, HD = 1, RD = 2;
  localparam int NV = 10;
  // {we, addr[16:0], wdata[7:0], exp_rdata[7:0]}
  localparam logic [33:0] VEC [0:NV-1] = '{
    {1'b1, 17'h00000, 8'hA5, 8'h00},
    {1'b1, 17'h1FFFF, 8'h5A, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h00, 8'h5A},
    {1'b1, 17'h12345, 8'h3C, 8'h00},
    {1'b0, 17'h12345, 8'h00, 8'h3C},
    {1'b1, 17'h12345, 8'hC3, 8'h00},
    {1'b0, 17'h12345, 8'h00, 8'hC3},
    {1'b1, 17'h0ABCE, 8'hFF, 8'h00},
    {1'b0, 17'h0ABCE, 8'h00, 8'hFF}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, done, ce_n, oe_n, we_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [16:0] mem_addr;
  logic [7:0]  mem_m [0:63];
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  sram_ctrl #(.SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD), .READ_CYC(RD)) u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ready_o(ready), .done_o(done),
    .rdata_o(rdata), .mem_addr_o(mem_addr), .mem_ce_no(ce_n), .mem_oe_no(oe_n),
    .mem_we_no(we_n), .mem_dq_o(dq_o), .mem_dq_i(dq_i), .mem_dq_oe_o(dq_oe)
  );

  // behavioural memory; 8'hEE when not driving
  always_comb dq_i = (!ce_n && !oe_n && we_n) ? mem_m[mem_addr[5:0]] : 8'hEE;
  always @(negedge clk) if (!ce_n && !we_n && dq_oe) mem_m[mem_addr[5:0]] <= dq_o;

  function automatic logic [5:0] pv();
    return {ready, done, ce_n, oe_n, we_n, dq_oe};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge of the done cycle
  task automatic txn(input logic we, input logic [16:0] a, input logic [7:0] wd,
                     input logic [7:0] exp, input logic poke);
    int total;
    total = we ? SU + PW + HD : RD;
    chk("R2 ready before request", 32'(ready), 32'd1);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    for (int c = 1; c <= total; c++) begin
      @(negedge clk);
      if (poke && c < total) begin
        req_valid = 1'b1; req_we = ~we; req_addr = ~a; req_wdata = ~wd;
      end else begin
        req_valid = 1'b0;
      end
      if (!we) chk("R3 read pins", 32'(pv()), 32'b000010);
      else if (c <= SU) chk("R4 setup pins", 32'(pv()), 32'b000110);
      else if (c <= SU + PW) begin
        chk("R4 pulse pins", 32'(pv()), 32'b000101);
        chk("R4 write data", 32'(dq_o), 32'(wd));
      end else chk("R4 hold pins", 32'(pv()), 32'b000110);
      chk(poke ? "R9 address held while busy" : "R8 address", 32'(mem_addr), 32'(a));
    end
    @(negedge clk);
    chk(we ? "R4 done pins" : "R3 done pins", 32'(pv()), 32'b111110);
    if (!we) chk("R3 read data", 32'(rdata), 32'(exp));
  endtask

  initial begin
    logic [7:0] keep;
    for (int i = 0; i < 64; i++) mem_m[i] = 8'h00;
    #1;
    chk("R1 reset pins", 32'(pv()), 32'b101110);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 pins after reset", 32'(pv()), 32'b101110);
    chk("R1 rdata after reset", 32'(rdata), 32'd0);
    repeat (3) @(negedge clk);
    chk("R2 idle standby", 32'(pv()), 32'b101110);
    // table walk, back to back
    for (int v = 0; v < NV; v++)
      txn(VEC[v][33], VEC[v][32:16], VEC[v][15:8], VEC[v][7:0], 1'b0);
    @(negedge clk);
    chk("R10 done one cycle", 32'(pv()), 32'b101110);
    // busy request ignored
    txn(1'b1, 17'h00005, 8'h77, 8'h00, 1'b1);
    @(negedge clk);
    chk("R9 no transaction after busy request", 32'(pv()), 32'b101110);
    @(negedge clk);
    chk("R9 still idle", 32'(pv()), 32'b101110);
    txn(1'b0, 17'h00005, 8'h00, 8'h77, 1'b0);
    // write does not alter read data
    keep = rdata;
    txn(1'b1, 17'h00006, 8'h11, 8'h00, 1'b0);
    chk("R11 rdata kept across write", 32'(rdata), 32'(keep));
    repeat (2) @(negedge clk);
    chk("R2 standby after traffic", 32'(pv()), 32'b101110);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule